// File: doc/BRIEF.md
# Bus-Strobed Successive-Approximation Conversion Controller

This block is the digital core of an eight-channel, 8-bit analog-to-digital converter that sits on a microprocessor bus. The host drives three active-low strobes: chip select, write and read. The low five data lines carry a channel code. A write latches the code and starts a conversion. A read returns the last result and starts another conversion on the same channel. A write issued while read is held low keeps the old channel code and starts a conversion on it. The interrupt output falls when a result is ready. It rises again when the host next strobes write or read.

The channel code is decoded into a positive and a negative input selection for the external analog multiplexer. Three input arrangements are available: paired differential, single-ended against analog ground, and pseudo-differential against channel 8. The block runs a binary search over an external comparator. It presents a trial code and keeps each bit for which the comparator reports that the selected difference is at least the trial level. The strobes are asynchronous, so each one passes through a two-flop synchronizer before the block acts on it. Bus data that is to be latched must stay valid for at least three clocks after write is released. Outward, the data bus is split into an input, an output and an output-enable, ready for a pad.

Top module: `sar_bus_adc_ctrl`

## Requirements
- R1: After reset, intrN is high and dbOe is low. The output latch holds 0. The channel code is 00000, which selects CH1 positive and CH2 negative.
- R2: A cycle with csN and wrN low and rdN high loads dbIn into the channel code when write is released, then starts a conversion on the new code.
- R3: Asserting wrN while csN is low drives intrN high within four clocks.
- R4: If rdN is low for the whole of a write, the channel code is kept. dbOut shows the previous result with dbOe high, and a conversion starts on the kept code.
- R5: At the end of a conversion the result enters the output latch and intrN falls. intrN stays low until the next write or read strobe.
- R6: dbOe is high exactly while csN and rdN are both low, and dbOut then carries the output latch. Asserting a read with csN low drives intrN high.
- R7: Releasing a read that had no write inside it starts a new conversion on the current code. A write may follow at once.
- R8: With code bit 3 at 0, bits 2:1 pick the pair CH1/2, CH3/4, CH5/6 or CH7/8. Bit 0 at 0 makes the odd channel positive; at 1 the members swap. Bit 4 is ignored.
- R9: Code bits 4:3 = 01 select single-ended mode: bits 2:0 choose CH1..CH8 as positive, with analog ground as negative (negGnd high).
- R10: Code bits 4:3 = 11 select pseudo-differential mode: bits 2:0 = 000..110 choose CH1..CH7 as positive against CH8. Code 11111 selects nothing, and its result is 0.
- R11: The search tests bits from MSB to LSB, one per clock, starting at trial code 0x80. A negative difference gives 0. intrN falls 8 to 16 clocks after write is released.
- R12: Strobes with csN high have no effect. The channel code and intrN are unchanged, and dbOe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| wrN | input | 1 | Write strobe, active low, asynchronous |
| rdN | input | 1 | Read strobe, active low, asynchronous |
| dbIn | input | 5 | Low data lines, read as the channel code |
| dbOut | output | 8 | Output latch contents toward the bus pad |
| dbOe | output | 1 | Bus pad output enable (csN and rdN both low) |
| cmpIn | input | 1 | Comparator: selected difference is at least trialCode |
| posSel | output | 8 | One-hot positive input select, bit 0 = CH1 |
| negSel | output | 8 | One-hot negative input select, bit 0 = CH1 |
| negGnd | output | 1 | Negative input tied to analog ground |
| trialCode | output | 8 | Current successive-approximation trial level |
| intrN | output | 1 | Result-ready interrupt, active low |

## Verification
A wrong channel decode shows as a wrong result in the first read after that conversion. That read comes about a dozen clocks after the write, because every mode and pair arrangement converts a distinct known difference. A fault in the write/read tracking shows in one of two ways. Either intrN fails to fall within sixteen clocks, or the kept code is replaced, which the read after a read-held write reveals. Interrupt clear faults appear within four clocks of the strobe.

// File: rtl/sar_bus_adc_pkg.sv
package sar_bus_adc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int NUM_CH = 8;
  localparam int SYNC_STAGES = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleBus;  // capture dbIn into the holding register
    logic latchAddr;  // move held code into the channel-code latch
    logic startConv;  // begin a new successive approximation
    logic abortConv;  // drop any conversion in flight
  } ctl_strobes_t;
endpackage

// File: rtl/sar_bus_sync.sv
module sar_bus_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_W-WIDTH-1:0], asyncIn};
  end

  assign syncOut = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/sar_bus_mux_decode.sv
module sar_bus_mux_decode #(
  parameter int ADDR_W = 5,
  parameter int NUM_CH = 8
) (
  input  logic [ADDR_W-1:0] chanCode,
  output logic [NUM_CH-1:0] posSel,
  output logic [NUM_CH-1:0] negSel,
  output logic              negGnd,
  output logic              selValid
);
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam logic [CH_IDX_W-1:0] LAST_CH = CH_IDX_W'(NUM_CH - 1);

  logic [CH_IDX_W-1:0] idxA, idxB, idxTmp;

  always_comb begin
    posSel   = '0;
    negSel   = '0;
    negGnd   = 1'b0;
    selValid = 1'b1;
    idxA     = {chanCode[CH_IDX_W-1:1], 1'b0};
    idxB     = {chanCode[CH_IDX_W-1:1], 1'b1};
    if (!chanCode[3]) begin
      // paired differential, bit 0 swaps the pair
      if (chanCode[0]) begin
        idxTmp = idxA;
        idxA   = idxB;
        idxB   = idxTmp;
      end else begin
        idxTmp = idxA;
      end
      posSel[idxA] = 1'b1;
      negSel[idxB] = 1'b1;
    end else begin
      idxTmp = chanCode[CH_IDX_W-1:0];
      if (!chanCode[4]) begin
        posSel[idxTmp] = 1'b1;
        negGnd         = 1'b1;
      end else if (idxTmp != LAST_CH) begin
        posSel[idxTmp]  = 1'b1;
        negSel[LAST_CH] = 1'b1;
      end else begin
        selValid = 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_bus_datapath.sv
module sar_bus_datapath
  import sar_bus_adc_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int NCH = NUM_CH
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctl_strobes_t   ctl,
  input  logic [AW-1:0]  dbIn,
  input  logic           cmpIn,
  output logic [NCH-1:0] posSel,
  output logic [NCH-1:0] negSel,
  output logic           negGnd,
  output logic [DW-1:0]  trialCode,
  output logic [DW-1:0]  outLatch,
  output logic           convDone
);
  localparam logic [DW-1:0] MSB_MASK = {1'b1, {(DW-1){1'b0}}};

  logic [AW-1:0] addrHold, addrLatch;
  logic [DW-1:0] bitMask, sarAcc;
  logic          busy, selValid, cmpEff;

  sar_bus_mux_decode #(.ADDR_W(AW), .NUM_CH(NCH)) uDecode (
    .chanCode (addrLatch),
    .posSel   (posSel),
    .negSel   (negSel),
    .negGnd   (negGnd),
    .selValid (selValid)
  );

  assign cmpEff    = cmpIn & selValid;
  assign trialCode = sarAcc | bitMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold  <= '0;
      addrLatch <= '0;
      bitMask   <= '0;
      sarAcc    <= '0;
      busy      <= 1'b0;
      outLatch  <= '0;
      convDone  <= 1'b0;
    end else begin
      convDone <= 1'b0;
      if (ctl.sampleBus) addrHold <= dbIn;
      if (ctl.latchAddr) addrLatch <= addrHold;
      if (ctl.abortConv) begin
        busy    <= 1'b0;
        bitMask <= '0;
      end else if (ctl.startConv) begin
        busy    <= 1'b1;
        bitMask <= MSB_MASK;
        sarAcc  <= '0;
      end else if (busy) begin
        if (cmpEff) sarAcc <= sarAcc | bitMask;
        bitMask <= bitMask >> 1;
        if (bitMask[0]) begin
          busy     <= 1'b0;
          convDone <= 1'b1;
          outLatch <= cmpEff ? (sarAcc | bitMask) : sarAcc;
        end
      end
    end
  end

  AST_TRIAL_MSB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startConv && !ctl.abortConv |=> trialCode == MSB_MASK); // R11
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> $past(busy)); // R11
  AST_NULL_CODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    convDone && !selValid |-> outLatch == '0); // R10
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(posSel) && $onehot0(negSel)); // R8
  AST_CODE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchAddr |=> $stable(addrLatch)); // R4
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_bus_adc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csA,
  input  logic         wrA,
  input  logic         rdA,
  input  logic         convDone,
  output ctl_strobes_t ctl,
  output logic         intrN
);
  logic wrPrev, rdPrev, wrCycle, rdCycle, rdHeld, wrInRead;
  logic wrAssert, wrRelease, rdAssert, rdRelease;

  always_comb begin
    wrAssert      = wrA & ~wrPrev & csA;
    wrRelease     = wrCycle & ~wrA;
    rdAssert      = rdA & ~rdPrev & csA;
    rdRelease     = rdCycle & ~rdA;
    ctl.sampleBus = wrCycle & wrA;
    ctl.abortConv = wrAssert;
    ctl.latchAddr = wrRelease & ~rdHeld;
    ctl.startConv = wrRelease | (rdRelease & ~wrInRead);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b0;
      rdPrev   <= 1'b0;
      wrCycle  <= 1'b0;
      rdCycle  <= 1'b0;
      rdHeld   <= 1'b0;
      wrInRead <= 1'b0;
      intrN    <= 1'b1;
    end else begin
      wrPrev <= wrA;
      rdPrev <= rdA;

      if (wrAssert) begin
        wrCycle <= 1'b1;
        rdHeld  <= rdA;
      end else if (wrRelease) begin
        wrCycle <= 1'b0;
      end else if (wrCycle && !rdA) begin
        rdHeld <= 1'b0;
      end

      if (rdAssert) begin
        rdCycle  <= 1'b1;
        wrInRead <= wrCycle;
      end else if (rdRelease) begin
        rdCycle  <= 1'b0;
        wrInRead <= 1'b0;
      end else if (rdCycle && wrCycle) begin
        wrInRead <= 1'b1;
      end

      if (convDone) intrN <= 1'b0;
      else if (wrAssert || rdAssert) intrN <= 1'b1;
    end
  end

  AST_INTR_FALL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intrN) |-> $past(convDone)); // R5
  AST_INTR_RISE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intrN) |-> $past(csA)); // R12
  AST_ONE_STROBE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.startConv && ctl.abortConv)); // R7
endmodule

// File: rtl/sar_bus_adc_ctrl.sv
module sar_bus_adc_ctrl
  import sar_bus_adc_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int NCH = NUM_CH,
  parameter int SYNC_N = SYNC_STAGES
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           csN,
  input  logic           wrN,
  input  logic           rdN,
  input  logic [AW-1:0]  dbIn,
  output logic [DW-1:0]  dbOut,
  output logic           dbOe,
  input  logic           cmpIn,
  output logic [NCH-1:0] posSel,
  output logic [NCH-1:0] negSel,
  output logic           negGnd,
  output logic [DW-1:0]  trialCode,
  output logic           intrN
);
  logic [2:0]   strobeSync;
  ctl_strobes_t ctl;
  logic         convDone;

  sar_bus_sync #(.WIDTH(3), .STAGES(SYNC_N)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({~csN, ~wrN, ~rdN}),
    .syncOut (strobeSync)
  );

  sar_bus_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .csA      (strobeSync[2]),
    .wrA      (strobeSync[1]),
    .rdA      (strobeSync[0]),
    .convDone (convDone),
    .ctl      (ctl),
    .intrN    (intrN)
  );

  sar_bus_datapath #(.DW(DW), .AW(AW), .NCH(NCH)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dbIn      (dbIn),
    .cmpIn     (cmpIn),
    .posSel    (posSel),
    .negSel    (negSel),
    .negGnd    (negGnd),
    .trialCode (trialCode),
    .outLatch  (dbOut),
    .convDone  (convDone)
  );

  // asynchronous read path toward the pad
  assign dbOe = ~csN & ~rdN;
endmodule

// File: tb/sar_bus_adc_ctrl_test.sv
module sar_bus_adc_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1;
  logic [4:0] tbDb = '0;
  logic [7:0] dbOut, trialCode, posSel, negSel;
  logic dbOe, negGnd, intrN, cmpIn;
  int checks = 0;
  int errors = 0;

  // CH1..CH8 analog levels in codes
  localparam int ANA [8] = '{200, 10, 33, 77, 150, 5, 90, 40};
  // {channel code, expected result}
  localparam logic [12:0] VEC [15] = '{
    {5'b00000, 8'd190}, {5'b00001, 8'd0},   {5'b00010, 8'd0},
    {5'b00011, 8'd44},  {5'b00100, 8'd145}, {5'b10100, 8'd145},
    {5'b00110, 8'd50},  {5'b00111, 8'd0},   {5'b01011, 8'd77},
    {5'b01111, 8'd40},  {5'b01100, 8'd150}, {5'b11000, 8'd160},
    {5'b11010, 8'd0},   {5'b11110, 8'd50},  {5'b11111, 8'd0}
  };

  always #4 clk = ~clk;

  sar_bus_adc_ctrl uut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .dbIn(tbDb), .dbOut(dbOut), .dbOe(dbOe), .cmpIn(cmpIn),
    .posSel(posSel), .negSel(negSel), .negGnd(negGnd),
    .trialCode(trialCode), .intrN(intrN)
  );

  // analog side: multiplexer plus comparator
  always_comb begin
    int posV, negV;
    posV = 0;
    negV = 0;
    for (int i = 0; i < 8; i++) begin
      if (posSel[i]) posV = ANA[i];
      if (negSel[i]) negV = ANA[i];
    end
    cmpIn = (posV >= negV) && ((posV - negV) >= int'(trialCode));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] code);
    @(negedge clk); tbDb = code; csN = 1'b0; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic doRead(output logic [7:0] val, output logic oe);
    @(negedge clk); csN = 1'b0; rdN = 1'b0;
    repeat (3) @(negedge clk);
    val = dbOut; oe = dbOe;
    rdN = 1'b1; csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic waitIntr(output int cyc);
    cyc = 0;
    while (intrN && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic oe;
    int cyc;
    string tag;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(intrN == 1'b1, "R1 intrN", intrN, 1);
    chk(dbOe == 1'b0, "R1 dbOe", dbOe, 0);
    doRead(v, oe);
    chk(v == 8'd0, "R1 latch", v, 0);
    chk(oe == 1'b1, "R6 oe", oe, 1);
    // R7 read release converts on reset code (CH1-CH2)
    waitIntr(cyc);
    chk(intrN == 1'b0, "R7 intr", intrN, 0);
    doRead(v, oe);
    chk(v == 8'd190, "R1 code", v, 190);

    // vector walk: R2 R5 R6 R8 R9 R10 R11
    for (int i = 0; i < 15; i++) begin
      logic [4:0] code;
      code = VEC[i][12:8];
      if (!code[3]) tag = "R8";
      else if (!code[4]) tag = "R9";
      else tag = "R10";
      doWrite(code);
      waitIntr(cyc);
      chk(intrN == 1'b0, "R5 intr fell", intrN, 0);
      repeat (10) @(negedge clk);
      chk(intrN == 1'b0, "R5 intr held", intrN, 0);
      doRead(v, oe);
      chk(v == VEC[i][7:0], {"R2 ", tag}, v, VEC[i][7:0]);
      chk(intrN == 1'b1, "R6 intr clear", intrN, 1);
    end

    // R11 conversion latency from write release
    @(negedge clk); tbDb = 5'b01011; csN = 1'b0; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    cyc = 0;
    while (intrN && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (cyc == 4) csN = 1'b1;
    end
    chk(cyc >= 8 && cyc <= 16, "R11 latency", cyc, 12);
    doRead(v, oe);
    chk(v == 8'd77, "R11 result", v, 77);
    waitIntr(cyc);

    // R4 read held through write keeps code 01011
    @(negedge clk); tbDb = 5'b00000; csN = 1'b0; rdN = 1'b0;
    repeat (3) @(negedge clk);
    chk(dbOe == 1'b1 && dbOut == 8'd77, "R4 old data", dbOut, 77);
    wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    repeat (4) @(negedge clk);
    rdN = 1'b1; csN = 1'b1;
    waitIntr(cyc);
    chk(intrN == 1'b0, "R4 started", intrN, 0);
    doRead(v, oe);
    chk(v == 8'd77, "R4 kept code", v, 77);
    waitIntr(cyc);

    // R3 write assert clears intr
    @(negedge clk); tbDb = 5'b00000; csN = 1'b0; wrN = 1'b0;
    repeat (4) @(negedge clk);
    chk(intrN == 1'b1, "R3 intr clear", intrN, 1);
    wrN = 1'b1;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    waitIntr(cyc);
    doRead(v, oe);
    chk(v == 8'd190, "R3 result", v, 190);
    waitIntr(cyc);

    // R12 strobes without chip select
    @(negedge clk); tbDb = 5'b01111; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    repeat (4) @(negedge clk);
    rdN = 1'b0;
    repeat (3) @(negedge clk);
    chk(dbOe == 1'b0, "R12 bus", dbOe, 0);
    rdN = 1'b1;
    repeat (4) @(negedge clk);
    chk(intrN == 1'b0, "R12 intr", intrN, 0);
    doRead(v, oe);
    chk(v == 8'd190, "R12 code", v, 190);
    waitIntr(cyc);
    doRead(v, oe);
    chk(v == 8'd190, "R12 code kept", v, 190);

    // R7 write right after a read
    doWrite(5'b01100);
    waitIntr(cyc);
    doRead(v, oe);
    chk(v == 8'd150, "R7 back to back", v, 150);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule